// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block decides when a new output-driver impedance code may take effect. A comparator outside the block reports each cycle whether the driver should become stronger or weaker. The block turns that report into one-step changes of a held calibration code. A change is allowed only in a cycle that leaves the data outputs undriven. Changes are also spaced out by a counter that runs on every clock, whatever the cycle is doing.

The surrounding interface logic tells the block, once per cycle, whether the cycle drives the outputs and what level the output-enable control has. When output enable is high, the outputs are held off even if a read was started, so that cycle is safe for an update. The block also counts the undriven cycles after reset and raises a flag once enough have gone by for the driver to have settled.

Top module: `imp_update_sched`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, loads the code to mid-scale (binary 100000 for the default 6-bit code, value 32). It also clears `calDone`, clears `updPulse` and clears the spacing and settling counts.
- R2: The scheduler counts rising edges since reset or since the last applied update, and this count stops at INTERVAL (default 32). An update is applied only at an edge where the count already stands at INTERVAL. Two updates are therefore never closer than INTERVAL+1 edges.
- R3: The spacing count advances on every edge whatever the cycle type. After 33 or more consecutive output-driving cycles, the waiting update is applied at the first following edge that is eligible.
- R4: An edge is eligible when `outActive` is 0 or `oeHigh` is 1 in that cycle. At a non-eligible edge (`outActive`=1 and `oeHigh`=0) the code never changes.
- R5: Each applied update moves the code by exactly one step. It goes up by one when `cmpUp` is 1 at the applying edge and down by one when `cmpUp` is 0.
- R6: The code saturates. An up step at all-ones (63) leaves it at 63, and a down step at zero leaves it at 0.
- R7: `calDone` rises after exactly SETTLE (default 1024) eligible edges since reset. Non-eligible edges do not count toward this total. Once high, `calDone` stays high until reset.
- R8: `updPulse` is high for exactly the one cycle that follows each applying edge, which is the cycle in which the new code first appears. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| outActive | input | 1 | Current cycle would drive the data outputs |
| oeHigh | input | 1 | Output-enable control is high (outputs held off) in this cycle |
| cmpUp | input | 1 | Comparator request: 1 means a stronger driver (code up), 0 means a weaker driver (code down) |
| impCode | output | CODE_W (6) | Calibration code in use |
| updPulse | output | 1 | One-cycle strobe marking a newly applied code |
| calDone | output | 1 | Power-up settling complete |

## Verification
The bench uses the default parameters: a 6-bit code, a spacing of 32 and a settling total of 1024. With these values the full walk from mid-scale up to the all-ones limit and down to zero takes only a few thousand cycles, so both saturation limits are reached. The exact edge on which the settling flag rises is also reached, with output-driving cycles mixed in so the bench can confirm they are not counted. A reference model in the bench predicts the code, the strobe and the flag on every edge. The bench also measures the gap between strobes and checks the 33-cycle blocking case with fixed expected values.

// File: rtl/imp_sched_pkg.sv
package imp_sched_pkg;
  // strobes from the control half to the code datapath
  typedef struct packed {
    logic apply;  // apply one step at this edge
    logic up;     // direction of the step
  } ctrl_strb_t;
endpackage

// File: rtl/imp_sched_ctrl.sv
module imp_sched_ctrl #(
  parameter int INTERVAL = 32,
  parameter int SETTLE   = 1024
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      outActive,
  input  logic                      oeHigh,
  input  logic                      cmpUp,
  output imp_sched_pkg::ctrl_strb_t strb,
  output logic                      calDone
);
  localparam int GAP_W = $clog2(INTERVAL + 1);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(INTERVAL);
  localparam logic [SET_W-1:0] SET_MAX  = SET_W'(SETTLE);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE - 1);

  logic [GAP_W-1:0] gapCnt;
  logic [SET_W-1:0] settleCnt;
  logic eligible, pending, settleTick;

  assign eligible   = !outActive || oeHigh;
  assign pending    = (gapCnt == GAP_MAX);
  assign settleTick = eligible && (settleCnt != SET_MAX);

  always_comb begin
    strb.apply = pending && eligible;
    strb.up    = cmpUp;
  end

  // spacing counter: runs on every edge, restarts when an update lands
  always_ff @(posedge clk) begin
    if (rst)              gapCnt <= '0;
    else if (strb.apply)  gapCnt <= '0;
    else if (!pending)    gapCnt <= gapCnt + 1'b1;
  end

  // settling counter over eligible (non-driving) edges
  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
      calDone   <= 1'b0;
    end else if (settleTick) begin
      settleCnt <= settleCnt + 1'b1;
      if (settleCnt == SET_LAST) calDone <= 1'b1;
    end
  end

  p_gap_bound_r2: assert property (@(posedge clk) disable iff (rst)
    gapCnt <= GAP_MAX);

  p_gap_restart_r2: assert property (@(posedge clk) disable iff (rst)
    strb.apply |=> (gapCnt == '0));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    calDone |=> calDone);

  p_done_count_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(calDone) |-> (settleCnt == SET_MAX));
endmodule

// File: rtl/imp_sched_code.sv
module imp_sched_code #(
  parameter int CODE_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  imp_sched_pkg::ctrl_strb_t strb,
  output logic [CODE_W-1:0]         impCode,
  output logic                      updPulse
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] codeNext;
  logic atTop, atBot;

  assign atTop = (impCode == CODE_MAX);
  assign atBot = (impCode == '0);

  always_comb begin
    codeNext = impCode;
    if (strb.up && !atTop)       codeNext = impCode + 1'b1;
    else if (!strb.up && !atBot) codeNext = impCode - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      impCode  <= CODE_MID;
      updPulse <= 1'b0;
    end else begin
      updPulse <= strb.apply;
      if (strb.apply) impCode <= codeNext;
    end
  end

  p_change_marked_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(impCode)) |-> updPulse);

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    updPulse |=> !updPulse);

  p_one_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && updPulse) |->
      ((impCode == $past(impCode) + 1'b1) || (impCode == $past(impCode) - 1'b1)
       || (impCode == $past(impCode))));
endmodule

// File: rtl/imp_update_sched.sv
module imp_update_sched #(
  parameter int CODE_W   = 6,
  parameter int INTERVAL = 32,
  parameter int SETTLE   = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              outActive,
  input  logic              oeHigh,
  input  logic              cmpUp,
  output logic [CODE_W-1:0] impCode,
  output logic              updPulse,
  output logic              calDone
);
  imp_sched_pkg::ctrl_strb_t strb;

  imp_sched_ctrl #(.INTERVAL(INTERVAL), .SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rst(rst), .outActive(outActive), .oeHigh(oeHigh),
    .cmpUp(cmpUp), .strb(strb), .calDone(calDone)
  );

  imp_sched_code #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .strb(strb), .impCode(impCode), .updPulse(updPulse)
  );

  p_quiet_active_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(outActive) && !$past(oeHigh)) |-> $stable(impCode));

  p_quiet_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(outActive) && !$past(oeHigh)) |-> !updPulse);
endmodule

// File: tb/imp_update_sched_bench.sv
module imp_update_sched_bench;
  localparam int CODE_W = 6;
  localparam int INTERVAL = 32;
  localparam int SETTLE = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic outActive = 1'b0, oeHigh = 1'b0, cmpUp = 1'b0;
  logic [CODE_W-1:0] impCode;
  logic updPulse, calDone;

  int total = 0, bad = 0;
  int expGap, expCode, expSettle, sinceLast;
  bit expPulse, expDone, seenPulse;

  always #5 clk = ~clk;

  imp_update_sched #(.CODE_W(CODE_W), .INTERVAL(INTERVAL), .SETTLE(SETTLE)) u_imp_update_sched (
    .clk(clk), .rst(rst), .outActive(outActive), .oeHigh(oeHigh), .cmpUp(cmpUp),
    .impCode(impCode), .updPulse(updPulse), .calDone(calDone)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic a, input logic o, input logic u);
    bit elig;
    outActive = a; oeHigh = o; cmpUp = u;
    elig = !a || o;
    @(posedge clk);
    if (rst) begin
      expGap = 0; expCode = 32; expSettle = 0; expPulse = 0; expDone = 0;
      seenPulse = 0; sinceLast = 0;
    end else begin
      if (expGap == INTERVAL && elig) begin
        if (u && expCode < 63) expCode++;
        else if (!u && expCode > 0) expCode--;
        expGap = 0; expPulse = 1;
      end else begin
        if (expGap < INTERVAL) expGap++;
        expPulse = 0;
      end
      if (elig && expSettle < SETTLE) expSettle++;
      expDone = (expSettle >= SETTLE);
    end
    #2;
    check("R4/R5 code", impCode, expCode);
    check("R8 pulse", updPulse, expPulse);
    check("R7 done", calDone, expDone);
    if (!rst) begin
      sinceLast++;
      if (updPulse) begin
        if (seenPulse) check("R2 spacing ok", (sinceLast >= INTERVAL + 1) ? 1 : 0, 1);
        seenPulse = 1; sinceLast = 0;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 code mid", impCode, 32);
    check("R1 done low", calDone, 0);
    check("R1 pulse low", updPulse, 0);

    // R3/R4: 40 driving cycles block the due update
    for (int i = 0; i < 40; i++) cyc(1, 0, 1);
    check("R3 held during reads", impCode, 32);
    check("R4 no pulse during reads", updPulse, 0);
    // a read cycle with output enable high is eligible
    cyc(1, 1, 1);
    check("R3 applied at first eligible", impCode, 33);
    check("R3 pulse at first eligible", updPulse, 1);
    cyc(0, 0, 1);
    check("R8 pulse one cycle", updPulse, 0);

    // R2: spacing of exactly INTERVAL+1 edges with idle cycles
    for (int i = 0; i < INTERVAL - 1; i++) cyc(0, 0, 1);
    check("R2 not early", impCode, 33);
    cyc(0, 0, 1);
    check("R2 applied on time", impCode, 34);

    // R5: step down
    for (int i = 0; i < INTERVAL + 1; i++) cyc(0, 0, 0);
    check("R5 down step", impCode, 33);

    // R6: saturate high, then low
    for (int i = 0; i < 40 * (INTERVAL + 1); i++) cyc(0, 0, 1);
    check("R6 top limit", impCode, 63);
    for (int i = 0; i < 70 * (INTERVAL + 1); i++) cyc(0, 1, 0);
    check("R6 bottom limit", impCode, 0);

    // R7: settle count over eligible edges only
    do_reset();
    for (int i = 0; i < SETTLE - 1; i++) begin
      cyc(0, 0, 1);
      if (i % 4 == 0) cyc(1, 0, 1);
    end
    check("R7 not yet done", calDone, 0);
    cyc(1, 0, 1);
    check("R7 read not counted", calDone, 0);
    cyc(0, 0, 1);
    check("R7 done at count", calDone, 1);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0);
    check("R7 sticky", calDone, 1);

    do_reset();
    check("R1 done cleared", calDone, 0);
    check("R1 code reloaded", impCode, 32);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule